// File: doc/BRIEF.md
# Read-to-Write Turnaround Command Sequencer

This block sits between the user side of a memory controller and a memory that shares one bidirectional data bus for reads and writes. The user side presents a group of command slots per transfer, slot 0 through slot 3 by default. Each slot holds a read, a write or nothing. The sequencer issues the commands one per memory clock in ascending slot order. Each issued command carries the index of the slot it came from, so the data path can line up its payload.

The memory returns read data later after a read than it takes write data after a write. A write issued too soon after a read would drive the bus while the memory is still driving it. The sequencer prevents this by holding a write until a programmable number of no-operation cycles has passed since the most recent read. A write followed by a read needs no gap. The most recent read is tracked across groups and across skipped idle slots.

The input uses a valid/ready handshake. Ready is high while no group is held. It is also high in the cycle in which the last command of the held group issues, so groups can stream with no bubble.

Top module: `cmd_turnaround_seq`

## Requirements
- R1: Commands of a group are issued one per cycle in ascending slot order, and `slot_o` carries the originating slot index of each issued command.
- R2: A group of only reads or only writes is issued as consecutive commands with no NOP cycles in between.
- R3: A write is never issued within `GAP_CYCLES` cycles after a read. When the write is the next command after the read, exactly `GAP_CYCLES` NOP cycles (default 8) stand between them.
- R4: A read that follows a write is issued in the next cycle, with no NOP.
- R5: The type of the last issued command is carried over into the next group. A read in the last slot followed by a write in slot 0 of the next group gets the full gap.
- R6: Idle slots (code 00 or 11) are skipped and emit nothing. They do not clear the read tracking. A group with no active slot is accepted and emits nothing.
- R7: `grp_ready_o` is low while a group is held and its last command has not yet issued. It is high in the cycle that last command issues, so the next group starts with no bubble.
- R8: Command encoding on `grp_cmd_i` (slot s in bits 2s+1:2s) and on `cmd_o` is 00 NOP, 01 read, 10 write. When no command issues, `cmd_o` is 00 and `slot_o` is 0.
- R9: Write data is never driven while read data is returning. The distance from a read to a later write always exceeds `RD_LAT - WR_LAT` cycles.
- R10: After reset `grp_ready_o` is high and `cmd_o` is NOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Memory clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| grp_valid_i | input | 1 | A command group is offered |
| grp_ready_o | output | 1 | The offered group is taken at this edge |
| grp_cmd_i | input | 2*NUM_SLOTS | Slot commands, slot s in bits 2s+1:2s |
| cmd_o | output | 2 | Command issued to memory this cycle |
| slot_o | output | SLOT_W | Slot index of the issued command |

## Verification
Uniform groups of all writes and all reads show that no gap appears where none is due. Alternating groups starting with a write, and starting with a read, separate read-to-write gaps from write-to-read continuity. Two back-to-back groups joined by a read in the last slot and a write in slot 0 show that read tracking crosses group boundaries. Groups containing idle and reserved codes show slot skipping. A held second group measures how long ready stays low and confirms there is no bubble at the hand-over.

// File: rtl/cmd_seq_pkg.sv
package cmd_seq_pkg;

  typedef enum logic [1:0] {
    CMD_NOP = 2'b00,
    CMD_RD  = 2'b01,
    CMD_WR  = 2'b10,
    CMD_RSV = 2'b11
  } cmd_e;

  function automatic logic cmd_active(input cmd_e c);
    return (c == CMD_RD) || (c == CMD_WR);
  endfunction

endpackage

// File: rtl/seq_group_reg.sv
module seq_group_reg
  import cmd_seq_pkg::*;
#(
  parameter int NUM_SLOTS = 4
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   load_i,
  input  logic [2*NUM_SLOTS-1:0] grp_cmd_i,
  input  logic [NUM_SLOTS-1:0]   clr_i,
  output cmd_e [NUM_SLOTS-1:0]   cmd_o,
  output logic [NUM_SLOTS-1:0]   pend_o
);

  cmd_e [NUM_SLOTS-1:0] cmd_q;
  logic [NUM_SLOTS-1:0] pend_q;
  logic [NUM_SLOTS-1:0] act_mask;

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_act
    assign act_mask[s] = cmd_active(cmd_e'(grp_cmd_i[2*s +: 2]));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      for (int s = 0; s < NUM_SLOTS; s++) cmd_q[s] <= CMD_NOP;
    end else if (load_i) begin
      pend_q <= act_mask;
      for (int s = 0; s < NUM_SLOTS; s++) cmd_q[s] <= cmd_e'(grp_cmd_i[2*s +: 2]);
    end else begin
      pend_q <= pend_q & ~clr_i;
    end
  end

  assign cmd_o  = cmd_q;
  assign pend_o = pend_q;

  // a new group may only land once the held one is finishing
  p_no_load_busy_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> ((pend_q & ~clr_i) == '0));

endmodule

// File: rtl/seq_slot_pick.sv
module seq_slot_pick #(
  parameter int NUM_SLOTS = 4,
  localparam int SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic [NUM_SLOTS-1:0] pend_i,
  output logic                 any_o,
  output logic [SLOT_W-1:0]    idx_o,
  output logic [NUM_SLOTS-1:0] oh_o
);

  always_comb begin
    idx_o = '0;
    for (int s = NUM_SLOTS - 1; s >= 0; s--) begin
      if (pend_i[s]) idx_o = SLOT_W'(s);
    end
  end

  assign oh_o  = pend_i & (~pend_i + NUM_SLOTS'(1));
  assign any_o = |pend_i;

endmodule

// File: rtl/seq_gap_timer.sv
module seq_gap_timer #(
  parameter int GAP_CYCLES = 8,
  localparam int CNT_W = $clog2(GAP_CYCLES + 2)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rd_issue_i,
  output logic open_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (rd_issue_i)       cnt_q <= CNT_W'(GAP_CYCLES);
    else if (cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
  end

  assign open_o = (cnt_q == '0);

  // once open, only a read can close the window again
  p_timer_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (open_o && !rd_issue_i) |=> open_o);

endmodule

// File: rtl/cmd_turnaround_seq.sv
module cmd_turnaround_seq
  import cmd_seq_pkg::*;
#(
  parameter int NUM_SLOTS  = 4,
  parameter int RD_LAT     = 8,
  parameter int WR_LAT     = 5,
  parameter int GAP_CYCLES = 8,
  localparam int SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   grp_valid_i,
  output logic                   grp_ready_o,
  input  logic [2*NUM_SLOTS-1:0] grp_cmd_i,
  output logic [1:0]             cmd_o,
  output logic [SLOT_W-1:0]      slot_o
);

  cmd_e [NUM_SLOTS-1:0] cmd_q;
  logic [NUM_SLOTS-1:0] pend;
  logic [NUM_SLOTS-1:0] head_oh;
  logic [NUM_SLOTS-1:0] clr;
  logic [SLOT_W-1:0]    head_idx;
  logic                 any_pend;
  logic                 gap_open;
  cmd_e                 head_cmd;
  logic                 issue;
  logic                 last_issue;
  logic                 rd_issue;
  logic                 accept;

  seq_group_reg #(.NUM_SLOTS(NUM_SLOTS)) u_grp (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (accept),
    .grp_cmd_i (grp_cmd_i),
    .clr_i     (clr),
    .cmd_o     (cmd_q),
    .pend_o    (pend)
  );

  seq_slot_pick #(.NUM_SLOTS(NUM_SLOTS)) u_pick (
    .pend_i (pend),
    .any_o  (any_pend),
    .idx_o  (head_idx),
    .oh_o   (head_oh)
  );

  seq_gap_timer #(.GAP_CYCLES(GAP_CYCLES)) u_gap (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_issue_i (rd_issue),
    .open_o     (gap_open)
  );

  assign head_cmd   = cmd_q[head_idx];
  // a write waits for the turnaround window; reads never wait
  assign issue      = any_pend && ((head_cmd != CMD_WR) || gap_open);
  assign rd_issue   = issue && (head_cmd == CMD_RD);
  assign clr        = issue ? head_oh : '0;
  assign last_issue = issue && ((pend & ~head_oh) == '0);

  assign grp_ready_o = !any_pend || last_issue;
  assign accept      = grp_valid_i && grp_ready_o;

  assign cmd_o  = issue ? head_cmd : CMD_NOP;
  assign slot_o = issue ? head_idx : '0;

  // output-side observer of read-to-write spacing
  localparam int SAT     = ((RD_LAT > GAP_CYCLES) ? RD_LAT : GAP_CYCLES) + 1;
  localparam int SINCE_W = $clog2(SAT + 1);
  localparam int TURN    = (RD_LAT > WR_LAT) ? (RD_LAT - WR_LAT) : 0;
  localparam logic [SINCE_W-1:0] SAT_L  = SINCE_W'(SAT);
  localparam logic [SINCE_W-1:0] GAP_L  = SINCE_W'(GAP_CYCLES);
  localparam logic [SINCE_W-1:0] TURN_L = SINCE_W'(TURN);

  logic [SINCE_W-1:0] since_rd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     since_rd_q <= SAT_L;
    else if (cmd_o == CMD_RD)        since_rd_q <= SINCE_W'(1);
    else if (since_rd_q != SAT_L)    since_rd_q <= since_rd_q + 1'b1;
  end

  p_rd_wr_gap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == CMD_WR) |-> (since_rd_q > GAP_L));

  p_bus_safe_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == CMD_WR) |-> (since_rd_q > TURN_L));

  p_one_slot_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(clr));

  p_nop_tag_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == CMD_NOP) |-> (slot_o == '0));

endmodule

// File: tb/cmd_turnaround_seq_test.sv
`timescale 1ns/1ps
module cmd_turnaround_seq_test;

  localparam logic [1:0] C_NOP = 2'b00;
  localparam logic [1:0] C_RD  = 2'b01;
  localparam logic [1:0] C_WR  = 2'b10;
  localparam logic [1:0] C_RSV = 2'b11;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       grp_valid = 1'b0;
  logic       grp_ready;
  logic [7:0] grp_cmd = '0;
  logic [1:0] cmd_o;
  logic [1:0] slot_o;

  int checks = 0;
  int failures = 0;

  logic [1:0] log_c [0:255];
  int         log_s [0:255];
  int         n_log = 0;
  logic       rec = 1'b0;

  always #2.5 clk = ~clk;

  cmd_turnaround_seq uut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .grp_valid_i (grp_valid),
    .grp_ready_o (grp_ready),
    .grp_cmd_i   (grp_cmd),
    .cmd_o       (cmd_o),
    .slot_o      (slot_o)
  );

  always @(posedge clk) begin
    #1;
    if (rec && n_log < 256) begin
      log_c[n_log] = cmd_o;
      log_s[n_log] = int'(slot_o);
      n_log++;
    end
  end

  function automatic logic [7:0] g4(logic [1:0] s0, logic [1:0] s1, logic [1:0] s2, logic [1:0] s3);
    return {s3, s2, s1, s0};
  endfunction

  function automatic byte ch(logic [1:0] c);
    case (c)
      C_NOP:   return "N";
      C_RD:    return "R";
      C_WR:    return "W";
      default: return "X";
    endcase
  endfunction

  task automatic begin_log();
    n_log = 0;
    rec = 1'b1;
  endtask

  task automatic push(logic [7:0] g);
    grp_valid = 1'b1;
    grp_cmd = g;
    while (!grp_ready) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic end_log();
    grp_valid = 1'b0;
    grp_cmd = '0;
    repeat (30) @(negedge clk);
    rec = 1'b0;
  endtask

  // compare log from first non-NOP against expected; everything after must be NOP
  task automatic check_seq(string tag, string ec, string es);
    int f = n_log;
    int bad = 0;
    checks++;
    for (int i = n_log - 1; i >= 0; i--) if (log_c[i] != C_NOP) f = i;
    for (int i = 0; i < ec.len() && bad == 0; i++) begin
      if (f + i >= n_log) begin
        $display("FAIL %s pos %0d: actual end-of-log expected %s", tag, i, string'(ec[i]));
        bad = 1;
      end else if (ch(log_c[f+i]) != ec[i]) begin
        $display("FAIL %s pos %0d: actual %s expected %s", tag, i, string'(ch(log_c[f+i])), string'(ec[i]));
        bad = 1;
      end else if (es[i] != "." && log_s[f+i] != int'(es[i] - "0")) begin
        $display("FAIL %s pos %0d slot: actual %0d expected %s", tag, i, log_s[f+i], string'(es[i]));
        bad = 1;
      end
    end
    for (int i = f + ec.len(); i < n_log && bad == 0; i++) begin
      if (log_c[i] != C_NOP) begin
        $display("FAIL %s trailing pos %0d: actual %s expected N", tag, i - f, string'(ch(log_c[i])));
        bad = 1;
      end
    end
    failures += bad;
  endtask

  task automatic t_reset();
    checks++;
    if (grp_ready !== 1'b1) begin
      failures++;
      $display("FAIL R10 ready after reset: actual %b expected 1", grp_ready);
    end
    checks++;
    if (cmd_o !== C_NOP || slot_o !== 2'd0) begin
      failures++;
      $display("FAIL R10 cmd after reset: actual %b/%0d expected 00/0", cmd_o, slot_o);
    end
  endtask

  task automatic t_all_wr();
    begin_log(); push(g4(C_WR, C_WR, C_WR, C_WR)); end_log();
    check_seq("R2 R1 all writes", "WWWW", "0123");
  endtask

  task automatic t_all_rd();
    begin_log(); push(g4(C_RD, C_RD, C_RD, C_RD)); end_log();
    check_seq("R2 all reads", "RRRR", "0123");
  endtask

  task automatic t_wr_rd();
    begin_log(); push(g4(C_WR, C_RD, C_WR, C_RD)); end_log();
    check_seq("R3 R4 wr-rd alternating", "WRNNNNNNNNWR", "01........23");
  endtask

  task automatic t_rd_wr();
    begin_log(); push(g4(C_RD, C_WR, C_RD, C_WR)); end_log();
    check_seq("R3 R4 rd-wr alternating", "RNNNNNNNNWRNNNNNNNNW", "0........12........3");
  endtask

  task automatic t_cross();
    begin_log();
    push(g4(C_WR, C_WR, C_WR, C_RD));
    push(g4(C_WR, C_RD, C_RD, C_RD));
    end_log();
    check_seq("R5 cross-group gap", "WWWRNNNNNNNNWRRR", "0123........0123");
  endtask

  task automatic t_idle();
    begin_log(); push(g4(C_RD, C_NOP, C_WR, C_NOP)); end_log();
    check_seq("R6 idle skipped keeps tracking", "RNNNNNNNNW", "0........2");
  endtask

  task automatic t_rsv();
    begin_log(); push(g4(C_RSV, C_WR, C_RSV, C_RD)); end_log();
    check_seq("R8 R6 reserved code idle", "WR", "13");
  endtask

  task automatic t_empty();
    begin_log(); push(g4(C_NOP, C_RSV, C_NOP, C_NOP));
    checks++;
    if (grp_ready !== 1'b1) begin
      failures++;
      $display("FAIL R6 ready after empty group: actual %b expected 1", grp_ready);
    end
    end_log();
    check_seq("R6 empty group", "", "");
  endtask

  task automatic t_ready();
    int low = 0;
    begin_log();
    grp_valid = 1'b1;
    grp_cmd = g4(C_RD, C_WR, C_NOP, C_NOP);
    @(negedge clk);
    grp_cmd = g4(C_WR, C_NOP, C_NOP, C_NOP);
    while (!grp_ready && low < 50) begin
      low++;
      @(negedge clk);
    end
    @(negedge clk);
    end_log();
    checks++;
    if (low != 9) begin
      failures++;
      $display("FAIL R7 ready low cycles: actual %0d expected 9", low);
    end
    check_seq("R7 no bubble at hand-over", "RNNNNNNNNWW", "0........10");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_all_wr();
    t_all_rd();
    t_wr_rd();
    t_rd_wr();
    t_cross();
    t_idle();
    t_rsv();
    t_empty();
    t_ready();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule